// File: doc/BRIEF.md
# Fetch and Data-Access Sequencer

This block is the control state machine of a small in-order processor that runs one instruction at a time. It keeps the program counter, issues one instruction fetch on an instruction port, and, when the returned instruction is a load or store, issues one data access on a data port. Any other instruction retires at once, the counter steps forward and the next fetch follows. The decoder, datapath, caches, address translation and interrupt logic sit outside. They reach this block only as strobes that arrive with the instruction response (memory reference, prefetch, early store-conditional failure, data address) or with a fetch attempt (translation fault).

Both ports use a request/accept handshake, a retry strobe and a separate response strobe. A request the port refuses is kept in a holding register. It is driven again only while the port raises its retry strobe. The block also takes control pulses to start after a programmed delay, to suspend, to switch out permanently, and to drain. A drain is acknowledged at once when no access is in flight. Otherwise the acknowledgement waits for the outstanding response, and no further fetch is launched after it.

Top module: `fetch_mem_sequencer`

## Requirements
- R1: After reset, state_o reads 0 (idle), pc_o equals RESET_PC, neither port request is high, and drain_ack_o, exec_done_o and proto_err_o are low.
- R2: state_o encodes idle=0, running=1, fetch-retry=2, fetch-wait=3, data-retry=4, data-wait=5, switched-out=6. An activate pulse is honoured only in idle. It moves to running, and the first fetch request is driven `delay_i` cycles after the first running cycle, so delay 0 gives a request in that first cycle.
- R3: A refused request puts the port's retry state in force and holds the address. No request is driven in that state until a retry strobe arrives. The retry cycle drives the held address, and the block moves to the wait state only if that cycle is accepted. Otherwise it stays in retry.
- R4: An instruction response for a non-memory instruction, or for a memory reference flagged as prefetch, pulses exec_done_o, advances pc_o by PC_STEP, and drives the next fetch in the following cycle.
- R5: An instruction response flagged as memory reference drives a data request in the next cycle at the data address captured with that response. The data response pulses exec_done_o, advances pc_o and fetches again.
- R6: A memory reference whose store-conditional fails early issues no data request and retires like a non-memory instruction.
- R7: A translation fault raised while a fetch is due suppresses the request, loads FAULT_PC into pc_o, and the fetch from FAULT_PC is driven in the next cycle.
- R8: A drain request in idle, running or switched-out state raises drain_ack_o for one cycle in the next cycle.
- R9: A drain request in a retry or wait state sets draining_o and waits. The awaited response raises drain_ack_o and launches no new fetch. An instruction response leaves pc_o unchanged, and a data response retires its instruction.
- R10: Suspend is honoured only in running state with no data access pending. It returns to idle and cancels a fetch still counting down.
- R11: Switch-out is honoured in idle or running state. It enters switched-out, cancels any countdown, and no request is driven afterwards until reset.
- R12: Any strobe out of place sets proto_err_o, which stays high until reset. This covers a retry or response in a non-matching state, a suspend, switch-out or activate where it is not honoured, and a drain while already draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| activate_i | input | 1 | Start pulse |
| delay_i | input | DLY_W | Start delay in cycles |
| suspend_i | input | 1 | Suspend pulse |
| switch_out_i | input | 1 | Switch-out pulse |
| drain_req_i | input | 1 | Drain request pulse |
| fetch_fault_i | input | 1 | Translation fault on the due fetch |
| if_req_o | output | 1 | Instruction request |
| if_addr_o | output | ADDR_W | Instruction address |
| if_accept_i | input | 1 | Instruction port accepts this cycle |
| if_retry_i | input | 1 | Instruction port retry strobe |
| if_rsp_i | input | 1 | Instruction response strobe |
| is_memref_i | input | 1 | Returned instruction is a load or store |
| is_prefetch_i | input | 1 | Memory reference is a prefetch |
| sc_fail_i | input | 1 | Store-conditional failed early |
| dmem_addr_i | input | ADDR_W | Data address of the returned instruction |
| d_req_o | output | 1 | Data request |
| d_addr_o | output | ADDR_W | Data address |
| d_accept_i | input | 1 | Data port accepts this cycle |
| d_retry_i | input | 1 | Data port retry strobe |
| d_rsp_i | input | 1 | Data response strobe |
| state_o | output | 3 | Sequencer state |
| pc_o | output | ADDR_W | Program counter |
| exec_done_o | output | 1 | Instruction retired pulse |
| drain_ack_o | output | 1 | Drain acknowledged pulse |
| draining_o | output | 1 | Drain waiting on a response |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
The bench refuses requests on both ports, then sends a retry that is refused again before one that is accepted. A design that advanced on the retry strobe alone would reach the wait state early, and one that replayed without a strobe would show a request in retry state. It measures the start latency for delays of 3 and 0, where an off-by-one timer moves the first request by a cycle. It injects a fault in the exact cycle a fetch is due, so a design that still issued or kept the old counter is caught. It drains during both an instruction wait and a data wait. A design that fetched after the deferred acknowledgement, or advanced the counter on a drained instruction response, breaks the event order or the counter value.

// File: rtl/seq_ctl_pkg.sv
package seq_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_IRETRY = 3'd2,
    ST_IWAIT  = 3'd3,
    ST_DRETRY = 3'd4,
    ST_DWAIT  = 3'd5,
    ST_SWOUT  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/req_holder.sv
module req_holder #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              accept_i,
  input  logic              retry_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              held_o,
  output logic              sent_o
);
  logic              held_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_o  = issue_i | (held_q & retry_i);
  assign addr_o = held_q ? addr_q : addr_i;
  assign sent_o = req_o & accept_i;
  assign held_o = held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      addr_q <= '0;
    end else if (issue_i && !accept_i) begin
      held_q <= 1'b1;
      addr_q <= addr_i;
    end else if (held_q && retry_i && accept_i) begin
      held_q <= 1'b0;
    end
  end

  a_r3_no_issue_while_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !held_q);
  a_r3_refused_is_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !accept_i) |=> (held_o && addr_o == $past(addr_i)));
endmodule

// File: rtl/launch_timer.sv
module launch_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             cancel_i,
  output logic             fire_o
);
  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;

  assign fire_o = armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cancel_i) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= delay_i;
    end else if (fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r2_fire_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !arm_i) |=> !fire_o);
endmodule

// File: rtl/fetch_mem_sequencer.sv
module fetch_mem_sequencer
  import seq_ctl_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              DLY_W    = 8,
  parameter int              PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100,
  parameter logic [ADDR_W-1:0] FAULT_PC = 32'h0000_0800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              activate_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              suspend_i,
  input  logic              switch_out_i,
  input  logic              drain_req_i,
  input  logic              fetch_fault_i,
  output logic              if_req_o,
  output logic [ADDR_W-1:0] if_addr_o,
  input  logic              if_accept_i,
  input  logic              if_retry_i,
  input  logic              if_rsp_i,
  input  logic              is_memref_i,
  input  logic              is_prefetch_i,
  input  logic              sc_fail_i,
  input  logic [ADDR_W-1:0] dmem_addr_i,
  output logic              d_req_o,
  output logic [ADDR_W-1:0] d_addr_o,
  input  logic              d_accept_i,
  input  logic              d_retry_i,
  input  logic              d_rsp_i,
  output logic [2:0]        state_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              exec_done_o,
  output logic              drain_ack_o,
  output logic              draining_o,
  output logic              proto_err_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, daddr_q;
  logic ipend_q, dpend_q, draining_q, done_q, ack_q, err_q;

  logic run_free, sus_ok, sw_ok, act_ok, fire;
  logic want_fetch, issue_if, issue_d;
  logic i_sent, i_held, d_sent, d_held;
  logic quiet, drain_now, drain_defer, drain_eff;
  logic i_rsp_ok, d_rsp_ok, needs_data, bad_strobe;

  assign run_free   = (state_q == ST_RUN) && !dpend_q;
  assign sus_ok     = suspend_i && run_free;
  assign sw_ok      = switch_out_i && (run_free || state_q == ST_IDLE);
  assign act_ok     = activate_i && (state_q == ST_IDLE);
  assign want_fetch = run_free && (ipend_q || fire) && !sus_ok && !sw_ok;
  assign issue_if   = want_fetch && !fetch_fault_i;
  assign issue_d    = (state_q == ST_RUN) && dpend_q;

  assign quiet       = state_q inside {ST_IDLE, ST_RUN, ST_SWOUT};
  assign drain_now   = drain_req_i && !draining_q && quiet;
  assign drain_defer = drain_req_i && !draining_q && !quiet;
  assign drain_eff   = draining_q || drain_defer;
  assign i_rsp_ok    = if_rsp_i && (state_q == ST_IWAIT);
  assign d_rsp_ok    = d_rsp_i && (state_q == ST_DWAIT);
  assign needs_data  = is_memref_i && !is_prefetch_i && !sc_fail_i;

  assign bad_strobe = (if_retry_i && state_q != ST_IRETRY)
                    | (d_retry_i && state_q != ST_DRETRY)
                    | (if_rsp_i && state_q != ST_IWAIT)
                    | (d_rsp_i && state_q != ST_DWAIT)
                    | (suspend_i && !run_free)
                    | (switch_out_i && !(run_free || state_q == ST_IDLE))
                    | (activate_i && state_q != ST_IDLE)
                    | (drain_req_i && draining_q);

  launch_timer #(.DLY_W(DLY_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (act_ok),
    .delay_i  (delay_i),
    .cancel_i (sus_ok | sw_ok),
    .fire_o   (fire)
  );

  req_holder #(.ADDR_W(ADDR_W)) i_ifetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (issue_if),
    .addr_i   (pc_q),
    .accept_i (if_accept_i),
    .retry_i  (if_retry_i && state_q == ST_IRETRY),
    .req_o    (if_req_o),
    .addr_o   (if_addr_o),
    .held_o   (i_held),
    .sent_o   (i_sent)
  );

  req_holder #(.ADDR_W(ADDR_W)) i_dacc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .issue_i  (issue_d),
    .addr_i   (daddr_q),
    .accept_i (d_accept_i),
    .retry_i  (d_retry_i && state_q == ST_DRETRY),
    .req_o    (d_req_o),
    .addr_o   (d_addr_o),
    .held_o   (d_held),
    .sent_o   (d_sent)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_ok)       state_d = ST_SWOUT;
        else if (act_ok) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (sus_ok)         state_d = ST_IDLE;
        else if (sw_ok)     state_d = ST_SWOUT;
        else if (issue_if)  state_d = i_sent ? ST_IWAIT : ST_IRETRY;
        else if (issue_d)   state_d = d_sent ? ST_DWAIT : ST_DRETRY;
      end
      ST_IRETRY: if (i_sent)   state_d = ST_IWAIT;
      ST_DRETRY: if (d_sent)   state_d = ST_DWAIT;
      ST_IWAIT:  if (i_rsp_ok) state_d = ST_RUN;
      ST_DWAIT:  if (d_rsp_ok) state_d = ST_RUN;
      ST_SWOUT:  state_d = ST_SWOUT;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pc_q       <= RESET_PC;
      daddr_q    <= '0;
      ipend_q    <= 1'b0;
      dpend_q    <= 1'b0;
      draining_q <= 1'b0;
      done_q     <= 1'b0;
      ack_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
      if (bad_strobe) err_q <= 1'b1;

      if (issue_if)        ipend_q <= 1'b0;
      else if (want_fetch) ipend_q <= 1'b1;
      if (want_fetch && fetch_fault_i) pc_q <= FAULT_PC;
      if (sus_ok || sw_ok) ipend_q <= 1'b0;
      if (issue_d)         dpend_q <= 1'b0;

      if (drain_now)   ack_q <= 1'b1;
      if (drain_defer) draining_q <= 1'b1;

      if (i_rsp_ok) begin
        if (drain_eff) begin
          draining_q <= 1'b0;
          ack_q      <= 1'b1;
        end else if (needs_data) begin
          dpend_q <= 1'b1;
          daddr_q <= dmem_addr_i;
        end else begin
          done_q  <= 1'b1;
          pc_q    <= pc_q + STEP;
          ipend_q <= 1'b1;
        end
      end

      if (d_rsp_ok) begin
        done_q <= 1'b1;
        pc_q   <= pc_q + STEP;
        if (drain_eff) begin
          draining_q <= 1'b0;
          ack_q      <= 1'b1;
        end else begin
          ipend_q <= 1'b1;
        end
      end
    end
  end

  assign state_o     = state_q;
  assign pc_o        = pc_q;
  assign exec_done_o = done_q;
  assign drain_ack_o = ack_q;
  assign draining_o  = draining_q;
  assign proto_err_o = err_q;

  a_r3_iretry_iff_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IRETRY) == i_held);
  a_r3_dretry_iff_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRETRY) == d_held);
  a_r5_one_port_at_a_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(if_req_o && d_req_o));
  a_r9_no_fetch_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_rsp_ok && drain_eff) |=> !if_req_o);
  a_r11_switched_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWOUT) |-> (!if_req_o && !d_req_o));
  a_r12_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

// File: tb/test_fetch_mem_sequencer.sv
module test_fetch_mem_sequencer;
  localparam int AW = 32;
  localparam int K_RET = 0, K_ACK = 1, K_IACC = 2, K_DACC = 3;

  typedef struct {
    int          kind;
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic activate, suspend, switch_out, drain_req, fetch_fault;
  logic [7:0] delay;
  logic if_accept, if_retry, if_rsp, is_memref, is_prefetch, sc_fail;
  logic d_accept, d_retry, d_rsp;
  logic [AW-1:0] dmem_addr;
  logic if_req, d_req, exec_done, drain_ack, draining, proto_err;
  logic [AW-1:0] if_addr, d_addr, pc;
  logic [2:0] state;

  int checks = 0, errors = 0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  fetch_mem_sequencer i_fetch_mem_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .activate_i(activate), .delay_i(delay),
    .suspend_i(suspend), .switch_out_i(switch_out), .drain_req_i(drain_req),
    .fetch_fault_i(fetch_fault), .if_req_o(if_req), .if_addr_o(if_addr),
    .if_accept_i(if_accept), .if_retry_i(if_retry), .if_rsp_i(if_rsp),
    .is_memref_i(is_memref), .is_prefetch_i(is_prefetch), .sc_fail_i(sc_fail),
    .dmem_addr_i(dmem_addr), .d_req_o(d_req), .d_addr_o(d_addr),
    .d_accept_i(d_accept), .d_retry_i(d_retry), .d_rsp_i(d_rsp),
    .state_o(state), .pc_o(pc), .exec_done_o(exec_done),
    .drain_ack_o(drain_ack), .draining_o(draining), .proto_err_o(proto_err)
  );

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic push(int kind, logic [31:0] val, string tag);
    exp_t e;
    e.kind = kind; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cmp(int kind, logic [31:0] val);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected event kind=%0d got=%0h exp=none", kind, val);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.val != val) begin
        errors++;
        $display("FAIL %s kind got=%0d exp=%0d value got=%0h exp=%0h",
                 e.tag, kind, e.kind, val, e.val);
      end
    end
  endtask

  // monitor: samples mid-cycle, after the driver has settled the inputs
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      if (exec_done)            cmp(K_RET, pc);
      if (drain_ack)            cmp(K_ACK, 32'h0);
      if (if_req && if_accept)  cmp(K_IACC, if_addr);
      if (d_req && d_accept)    cmp(K_DACC, d_addr);
    end
  end

  task automatic cyc();
    @(negedge clk);
    activate = 0; suspend = 0; switch_out = 0; drain_req = 0; fetch_fault = 0;
    if_retry = 0; if_rsp = 0; is_memref = 0; is_prefetch = 0; sc_fail = 0;
    d_retry = 0; d_rsp = 0;
  endtask

  task automatic wait_ireq(output int n);
    n = 0;
    for (int k = 0; k < 50; k++) begin
      cyc(); n++; #1;
      if (if_req) break;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int reqs;
    activate = 0; suspend = 0; switch_out = 0; drain_req = 0; fetch_fault = 0;
    if_retry = 0; if_rsp = 0; is_memref = 0; is_prefetch = 0; sc_fail = 0;
    d_retry = 0; d_rsp = 0; delay = 0; dmem_addr = 0;
    if_accept = 1; d_accept = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(); #1;
    chk(state == 3'd0, "R1 reset state", 32'(state), 0);
    chk(pc == 32'h100, "R1 reset pc", pc, 32'h100);
    chk(!if_req && !d_req, "R1 no request", {if_req, d_req}, 0);
    chk(!proto_err && !drain_ack && !exec_done, "R1 flags low", proto_err, 0);

    // R2: start with delay 3
    cyc(); activate = 1; delay = 8'd3;
    push(K_IACC, 32'h100, "R2 first fetch");
    wait_ireq(n);
    chk(n == 4, "R2 delay 3 latency", n, 4);

    // R4: plain instruction
    cyc(); if_rsp = 1;
    push(K_RET, 32'h104, "R4 retire"); push(K_IACC, 32'h104, "R4 next fetch");
    wait_ireq(n);
    chk(n == 1, "R4 fetch follows next cycle", n, 1);
    chk(pc == 32'h104, "R4 pc step", pc, 32'h104);

    // R5: load
    cyc(); if_rsp = 1; is_memref = 1; dmem_addr = 32'h40;
    push(K_DACC, 32'h40, "R5 data request");
    cyc(); #1;
    chk(d_req && d_addr == 32'h40, "R5 data request addr", d_addr, 32'h40);
    cyc(); #1;
    chk(state == 3'd5, "R5 data wait state", 32'(state), 5);
    cyc(); d_rsp = 1;
    push(K_RET, 32'h108, "R5 data retire"); push(K_IACC, 32'h108, "R5 fetch after data");
    wait_ireq(n);

    // R3: refused fetch, refused retry, accepted retry
    cyc(); if_rsp = 1; if_accept = 0;
    push(K_RET, 32'h10c, "R3 retire before refusal");
    cyc(); #1;
    chk(if_req == 1'b1, "R3 request driven while refused", 32'(if_req), 1);
    cyc(); #1;
    chk(state == 3'd2, "R3 enters fetch retry", 32'(state), 2);
    chk(if_req == 1'b0, "R3 quiet without retry strobe", 32'(if_req), 0);
    cyc(); if_retry = 1; #1;
    chk(if_req && if_addr == 32'h10c, "R3 replay of held address", if_addr, 32'h10c);
    cyc(); #1;
    chk(state == 3'd2, "R3 stays in retry after refused replay", 32'(state), 2);
    cyc(); if_retry = 1; if_accept = 1;
    push(K_IACC, 32'h10c, "R3 accepted replay");
    cyc(); #1;
    chk(state == 3'd3, "R3 wait after accepted replay", 32'(state), 3);

    // R3: refused data access
    cyc(); if_rsp = 1; is_memref = 1; dmem_addr = 32'h44; d_accept = 0;
    cyc();
    cyc(); #1;
    chk(state == 3'd4 && !d_req, "R3 data retry quiet", 32'(state), 4);
    cyc(); d_retry = 1; d_accept = 1;
    push(K_DACC, 32'h44, "R3 data replay");
    cyc(); #1;
    chk(state == 3'd5, "R3 data wait after replay", 32'(state), 5);
    cyc(); d_rsp = 1;
    push(K_RET, 32'h110, "R5 retire after replay"); push(K_IACC, 32'h110, "R5 fetch");
    cyc();

    // R6: store-conditional early fail
    cyc(); if_rsp = 1; is_memref = 1; sc_fail = 1;
    push(K_RET, 32'h114, "R6 retire"); push(K_IACC, 32'h114, "R6 fetch");
    cyc(); #1;
    chk(!d_req, "R6 no data request", 32'(d_req), 0);
    // R4: prefetch treated as plain
    cyc(); if_rsp = 1; is_memref = 1; is_prefetch = 1;
    push(K_RET, 32'h118, "R4 prefetch retire"); push(K_IACC, 32'h118, "R4 prefetch fetch");
    cyc(); #1;
    chk(!d_req, "R4 prefetch no data request", 32'(d_req), 0);

    // R7: translation fault on the due fetch
    cyc(); if_rsp = 1;
    push(K_RET, 32'h11c, "R7 retire before fault");
    cyc(); fetch_fault = 1; #1;
    chk(!if_req, "R7 no request on fault", 32'(if_req), 0);
    cyc();
    push(K_IACC, 32'h800, "R7 fetch from handler");
    #1;
    chk(pc == 32'h800, "R7 pc at handler", pc, 32'h800);

    // R9: drain during instruction wait
    cyc(); drain_req = 1;
    cyc(); #1;
    chk(draining && !drain_ack, "R9 draining waits", 32'(draining), 1);
    cyc(); if_rsp = 1;
    push(K_ACK, 0, "R9 deferred ack");
    reqs = 0;
    for (int k = 0; k < 4; k++) begin cyc(); #1; if (if_req) reqs++; end
    chk(reqs == 0, "R9 no fetch after drain", reqs, 0);
    chk(pc == 32'h800, "R9 pc unchanged", pc, 32'h800);

    // R10: suspend to idle
    cyc(); suspend = 1;
    cyc(); #1;
    chk(state == 3'd0, "R10 idle after suspend", 32'(state), 0);

    // R8: immediate drain in idle
    cyc(); drain_req = 1;
    push(K_ACK, 0, "R8 immediate ack");
    cyc(); #1;
    chk(drain_ack, "R8 ack next cycle", 32'(drain_ack), 1);

    // R2 delay 0, then R9 drain during data wait
    cyc(); activate = 1; delay = 8'd0;
    push(K_IACC, 32'h800, "R2 delay zero fetch");
    cyc(); #1;
    chk(if_req, "R2 delay 0 request in first running cycle", 32'(if_req), 1);
    cyc(); if_rsp = 1; is_memref = 1; dmem_addr = 32'h60;
    push(K_DACC, 32'h60, "R9 data before drain");
    cyc();
    cyc(); drain_req = 1;
    cyc(); d_rsp = 1;
    push(K_RET, 32'h804, "R9 data retire under drain"); push(K_ACK, 0, "R9 data drain ack");
    reqs = 0;
    for (int k = 0; k < 4; k++) begin cyc(); #1; if (if_req) reqs++; end
    chk(reqs == 0, "R9 no fetch after data drain", reqs, 0);

    // R10: suspend cancels a countdown
    cyc(); suspend = 1;
    cyc(); activate = 1; delay = 8'd5;
    cyc();
    cyc(); suspend = 1;
    reqs = 0;
    for (int k = 0; k < 10; k++) begin cyc(); #1; if (if_req) reqs++; end
    chk(reqs == 0 && state == 3'd0, "R10 countdown cancelled", reqs, 0);

    // R11: switch-out cancels a countdown
    cyc(); activate = 1; delay = 8'd5;
    cyc(); switch_out = 1;
    reqs = 0;
    for (int k = 0; k < 10; k++) begin cyc(); #1; if (if_req) reqs++; end
    chk(reqs == 0, "R11 no fetch after switch-out", reqs, 0);
    chk(state == 3'd6, "R11 switched-out state", 32'(state), 6);
    cyc(); drain_req = 1;
    push(K_ACK, 0, "R8 ack when switched out");
    cyc(); #1;
    chk(proto_err == 1'b0, "R12 no error on legal traffic", 32'(proto_err), 0);

    // R12: stray retry, then stray activate
    cyc(); if_retry = 1;
    cyc(); cyc(); #1;
    chk(proto_err == 1'b1, "R12 stray retry flagged", 32'(proto_err), 1);
    cyc(); activate = 1;
    cyc(); cyc(); #1;
    chk(state == 3'd6 && proto_err, "R11 activate ignored when switched out", 32'(state), 6);

    repeat (3) cyc();
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule